// File: doc/BRIEF.md
# I2C Wire-to-Transaction Bridge

This block sits on the two wires of an I2C bus as a target, watching the clock (SCL) and data (SDA) lines that a master drives. It turns the bit-level activity on those wires into byte-level requests on a simple downstream port. The requests are: open a transfer with an address, write a byte, read a byte, the master refused a byte, and close the transfer. It does not own a slave address. It answers on the wire for whatever target the address selects, and it passes the target's accept or refuse back to the master as ACK or NACK.

Both lines are taken into the system clock through two-flop synchronizers and compared with the previously seen levels to find edges. The bridge has its own SDA drive value. The level it returns to the bus is that drive ANDed with the master's SDA, which is how a wired-AND open-drain line behaves. Downstream requests are one-cycle pulses, and the target answers in the same cycle: a refuse flag for address and write requests, and a byte for read requests.

Top module: `i2c_wire_bridge`

## Requirements
- R1: A falling SDA while SCL is high is a START. START is accepted in any state, including mid-transfer, and begins collecting an address byte. A repeated START issues no close request and invalidates the current address.
- R2: A rising SDA while SCL is high is a STOP. STOP pulses `tgt_end_o` only when an address has been accepted and not yet closed. The bridge then returns to idle with no valid address.
- R3: Bits are sampled on SCL rising edges, MSB first, eight per byte. In the first byte after START, bits [7:1] are the target address (`tgt_addr_o`) and bit 0 is the direction, 1 for read and 0 for write.
- R4: On the ninth SCL rising edge the bridge pulses `tgt_start_o` for the first byte, or `tgt_write_o` (with `tgt_wdata_o`) for later bytes. If `tgt_nack_i` is low, the bridge drives SDA low until the next SCL falling edge (ACK).
- R5: If `tgt_nack_i` is high at that edge, the bridge leaves SDA released (NACK) and pulses `tgt_end_o` in the same cycle. It then ignores further SCL activity: no requests and no SDA drive until START.
- R6: After an accepted read address, and after each master ACK, the bridge pulses `tgt_read_o` on the first bit's rising edge and captures `tgt_rdata_i`. It presents that byte MSB first, one bit per rising edge, with each bit held until the following falling edge.
- R7: After eight read bits, the master's SDA at the ninth rising edge decides what follows. Low means read another byte. High pulses `tgt_mnack_o` once, and the bridge then ignores clocks until STOP or START.
- R8: `sda_o` equals the bridge's drive value ANDed with the synchronized master SDA, so a master driving low always reads low.
- R9: After reset, `sda_o` is high, both lines are taken as high, the bridge is idle, and no request is pulsed.
- R10: Every SCL falling edge releases the bridge's drive to high. When SCL and SDA change in the same sample, a START/STOP decision (made against the previous SCL level) takes priority and suppresses the clock edge.
- R11: At most one of `tgt_start_o`, `tgt_write_o`, `tgt_read_o` and `tgt_mnack_o` is high in any cycle, and each lasts one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous reset, active low |
| scl_i | input | 1 | Bus clock line as driven by the master |
| sda_i | input | 1 | Bus data line as driven by the master |
| sda_o | output | 1 | Bus data level seen by the master (bridge drive AND master SDA) |
| tgt_start_o | output | 1 | Pulse: open a transfer to `tgt_addr_o` in direction `tgt_rnw_o` |
| tgt_addr_o | output | 7 | Target address, valid with `tgt_start_o` |
| tgt_rnw_o | output | 1 | Direction, 1 for read, valid with `tgt_start_o` |
| tgt_write_o | output | 1 | Pulse: write `tgt_wdata_o` to the open target |
| tgt_wdata_o | output | 8 | Write byte, valid with `tgt_write_o` |
| tgt_nack_i | input | 1 | Same-cycle refuse flag for a start or write request |
| tgt_read_o | output | 1 | Pulse: fetch one byte from the open target |
| tgt_rdata_i | input | 8 | Same-cycle read byte for `tgt_read_o` |
| tgt_mnack_o | output | 1 | Pulse: the master refused the last read byte |
| tgt_end_o | output | 1 | Pulse: close the open transfer |

## Verification
The bench goes after an address the target refuses. A bridge that got this wrong would still ACK, or would fail to close the transfer, so the later STOP would close it a second time. A refused data byte is exercised too: a flawed bridge would keep issuing write requests for the clocks that follow. A read that ends in a master NACK checks that the byte fetch and the refuse pulse happen exactly once, and that further clocks produce neither reads nor low SDA. A START made by dropping SCL and SDA in the same sample, followed by a repeated START, exposes a bridge that misorders simultaneous edges or that closes the transfer on a repeated START.

// File: rtl/i2cb_pkg.sv
// Shared types for the I2C wire-to-transaction bridge.
// Assumes: 8-bit bytes, 7-bit addressing.
package i2cb_pkg;
    localparam int BYTE_W = 8;
    localparam int ADDR_W = BYTE_W - 1;

    typedef enum logic [2:0] {
        ST_IDLE,      // waiting for START
        ST_SHIFT_IN,  // collecting address or write byte
        ST_ACK,       // ninth clock of a master-to-target byte
        ST_SHIFT_OUT, // presenting a read byte
        ST_MACK,      // ninth clock of a read byte
        ST_MUTED      // master refused: ignore clocks
    } bridge_state_t;
endpackage

// File: rtl/i2cb_sync.sv
// Multi-stage synchronizer for a bundle of asynchronous lines.
// Assumes: each line is independent; reset value is the idle bus level.
module i2cb_sync #(
    parameter int WIDTH  = 2,
    parameter int STAGES = 2,
    parameter logic [WIDTH-1:0] IDLE_VAL = '1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d_i,
    output logic [WIDTH-1:0] q_o
);
    logic [WIDTH-1:0] pipe [STAGES];

    // first stage captures the raw lines
    always_ff @(posedge clk) begin
        if (!rst_n) pipe[0] <= IDLE_VAL;
        else        pipe[0] <= d_i;
    end

    genvar g;
    generate
        for (g = 1; g < STAGES; g++) begin : g_stage
            // later stages retime the previous stage
            always_ff @(posedge clk) begin
                if (!rst_n) pipe[g] <= IDLE_VAL;
                else        pipe[g] <= pipe[g-1];
            end
        end
    endgenerate

    assign q_o = pipe[STAGES-1];
endmodule

// File: rtl/i2cb_edge.sv
// Bus condition detector: compares synchronized SCL/SDA with the levels
// seen one sample earlier and emits START, STOP, SCL rise and SCL fall
// strobes. A START/STOP decision uses the earlier SCL level and, when it
// fires, suppresses a clock edge in the same sample.
// Assumes: inputs are already synchronized to clk.
module i2cb_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_s,
    input  logic sda_s,
    output logic ev_start,
    output logic ev_stop,
    output logic ev_rise,
    output logic ev_fall,
    output logic sda_seen
);
    logic scl_seen;
    logic sda_cond;
    logic scl_chg;

    // remember the levels of the previous sample
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            scl_seen <= 1'b1;
            sda_seen <= 1'b1;
        end else begin
            scl_seen <= scl_s;
            sda_seen <= sda_s;
        end
    end

    // classify the change between the previous and current sample
    always_comb begin
        sda_cond = (sda_s ^ sda_seen) & scl_seen;
        scl_chg  = scl_s ^ scl_seen;
        ev_start = sda_cond & ~sda_s;
        ev_stop  = sda_cond &  sda_s;
        ev_rise  = scl_chg  &  scl_s & ~sda_cond;
        ev_fall  = scl_chg  & ~scl_s & ~sda_cond;
    end

    assert_events_exclusive_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({ev_start, ev_stop, ev_rise, ev_fall}));

    assert_no_double_rise_R10: assert property (@(posedge clk) disable iff (!rst_n)
        ev_rise |=> !ev_rise);
endmodule

// File: rtl/i2cb_fsm.sv
// Byte engine: shifts address/write bytes in, forwards them as start or
// write requests, returns the target's ACK/NACK, fetches and shifts out
// read bytes, and handles the master's acknowledge.
// Assumes: target answers (nack, read data) combinationally in the
// request cycle; strobes from i2cb_edge are mutually exclusive.
module i2cb_fsm
    import i2cb_pkg::*;
#(
    parameter int DATA_W = BYTE_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ev_start,
    input  logic              ev_stop,
    input  logic              ev_rise,
    input  logic              ev_fall,
    input  logic              sda_now,
    output logic              drive_o,
    output logic              start_req,
    output logic [DATA_W-2:0] addr_o,
    output logic              rnw_o,
    output logic              write_req,
    output logic [DATA_W-1:0] wdata_o,
    input  logic              nack_i,
    output logic              read_req,
    input  logic [DATA_W-1:0] rdata_i,
    output logic              mnack_req,
    output logic              end_req
);
    localparam int CNT_W = $clog2(DATA_W);
    localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(DATA_W - 1);

    bridge_state_t     state_q;
    logic [CNT_W-1:0]  cnt_q;
    logic [DATA_W-1:0] shreg_q;
    logic              addr_ok_q;
    logic              rnw_q;
    logic              at_ack;

    // request strobes decoded from the current state and bus event
    always_comb begin
        at_ack    = ev_rise && (state_q == ST_ACK);
        start_req = at_ack && !addr_ok_q;
        write_req = at_ack &&  addr_ok_q;
        read_req  = ev_rise && (state_q == ST_SHIFT_OUT) && (cnt_q == '0);
        mnack_req = ev_rise && (state_q == ST_MACK) && sda_now;
        end_req   = (ev_stop && addr_ok_q) || (at_ack && nack_i);
        addr_o    = shreg_q[DATA_W-1:1];
        rnw_o     = shreg_q[0];
        wdata_o   = shreg_q;
    end

    // protocol state, shift register and SDA drive
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q   <= ST_IDLE;
            cnt_q     <= '0;
            shreg_q   <= '0;
            addr_ok_q <= 1'b0;
            rnw_q     <= 1'b0;
            drive_o   <= 1'b1;
        end else if (ev_start) begin
            state_q   <= ST_SHIFT_IN;
            cnt_q     <= '0;
            addr_ok_q <= 1'b0;
            drive_o   <= 1'b1;
        end else if (ev_stop) begin
            state_q   <= ST_IDLE;
            addr_ok_q <= 1'b0;
            drive_o   <= 1'b1;
        end else if (ev_fall) begin
            drive_o   <= 1'b1;
        end else if (ev_rise) begin
            case (state_q)
                ST_SHIFT_IN: begin
                    shreg_q <= {shreg_q[DATA_W-2:0], sda_now};
                    cnt_q   <= cnt_q + 1'b1;
                    drive_o <= 1'b1;
                    if (cnt_q == LAST_BIT) state_q <= ST_ACK;
                end
                ST_ACK: begin
                    cnt_q <= '0;
                    if (nack_i) begin
                        state_q   <= ST_IDLE;
                        addr_ok_q <= 1'b0;
                        drive_o   <= 1'b1;
                    end else begin
                        drive_o <= 1'b0;
                        if (!addr_ok_q) begin
                            addr_ok_q <= 1'b1;
                            rnw_q     <= shreg_q[0];
                            state_q   <= shreg_q[0] ? ST_SHIFT_OUT : ST_SHIFT_IN;
                        end else begin
                            state_q   <= rnw_q ? ST_SHIFT_OUT : ST_SHIFT_IN;
                        end
                    end
                end
                ST_SHIFT_OUT: begin
                    if (cnt_q == '0) begin
                        drive_o <= rdata_i[DATA_W-1];
                        shreg_q <= {rdata_i[DATA_W-2:0], 1'b0};
                    end else begin
                        drive_o <= shreg_q[DATA_W-1];
                        shreg_q <= {shreg_q[DATA_W-2:0], 1'b0};
                    end
                    cnt_q <= cnt_q + 1'b1;
                    if (cnt_q == LAST_BIT) state_q <= ST_MACK;
                end
                ST_MACK: begin
                    drive_o <= 1'b1;
                    cnt_q   <= '0;
                    state_q <= sda_now ? ST_MUTED : ST_SHIFT_OUT;
                end
                default: drive_o <= 1'b1;
            endcase
        end
    end

    assert_req_onehot_R11: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({start_req, write_req, read_req, mnack_req}));

    assert_start_pulse_R11: assert property (@(posedge clk) disable iff (!rst_n)
        start_req |=> !start_req);

    assert_read_pulse_R11: assert property (@(posedge clk) disable iff (!rst_n)
        read_req |=> !read_req);

    assert_ack_drives_low_R4: assert property (@(posedge clk) disable iff (!rst_n)
        ((start_req || write_req) && !nack_i) |=> !drive_o);

    assert_nack_releases_R5: assert property (@(posedge clk) disable iff (!rst_n)
        ((start_req || write_req) && nack_i) |=> (drive_o && state_q == ST_IDLE));

    assert_end_closes_R2: assert property (@(posedge clk) disable iff (!rst_n)
        end_req |=> !addr_ok_q);

    assert_fall_releases_R10: assert property (@(posedge clk) disable iff (!rst_n)
        ev_fall |=> drive_o);

    assert_muted_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_MUTED) |-> (!read_req && !start_req && !write_req && drive_o));
endmodule

// File: rtl/i2c_wire_bridge.sv
// Top of the I2C wire-to-transaction bridge: synchronizes the bus lines,
// detects bus conditions, runs the byte engine and forms the returned
// SDA level as bridge drive AND master SDA.
// Assumes: no clock stretching, 7-bit addressing, a single master.
module i2c_wire_bridge
    import i2cb_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scl_i,
    input  logic              sda_i,
    output logic              sda_o,
    output logic              tgt_start_o,
    output logic [ADDR_W-1:0] tgt_addr_o,
    output logic              tgt_rnw_o,
    output logic              tgt_write_o,
    output logic [BYTE_W-1:0] tgt_wdata_o,
    input  logic              tgt_nack_i,
    output logic              tgt_read_o,
    input  logic [BYTE_W-1:0] tgt_rdata_i,
    output logic              tgt_mnack_o,
    output logic              tgt_end_o
);
    logic [1:0] lines_s;
    logic ev_start, ev_stop, ev_rise, ev_fall;
    logic sda_seen;
    logic drive;

    i2cb_sync #(.WIDTH(2), .STAGES(SYNC_STAGES), .IDLE_VAL(2'b11)) i_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d_i   ({scl_i, sda_i}),
        .q_o   (lines_s)
    );

    i2cb_edge i_edge (
        .clk      (clk),
        .rst_n    (rst_n),
        .scl_s    (lines_s[1]),
        .sda_s    (lines_s[0]),
        .ev_start (ev_start),
        .ev_stop  (ev_stop),
        .ev_rise  (ev_rise),
        .ev_fall  (ev_fall),
        .sda_seen (sda_seen)
    );

    i2cb_fsm #(.DATA_W(BYTE_W)) i_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .ev_start  (ev_start),
        .ev_stop   (ev_stop),
        .ev_rise   (ev_rise),
        .ev_fall   (ev_fall),
        .sda_now   (lines_s[0]),
        .drive_o   (drive),
        .start_req (tgt_start_o),
        .addr_o    (tgt_addr_o),
        .rnw_o     (tgt_rnw_o),
        .write_req (tgt_write_o),
        .wdata_o   (tgt_wdata_o),
        .nack_i    (tgt_nack_i),
        .read_req  (tgt_read_o),
        .rdata_i   (tgt_rdata_i),
        .mnack_req (tgt_mnack_o),
        .end_req   (tgt_end_o)
    );

    // wired-AND of the bridge drive and the master's line
    assign sda_o = drive & sda_seen;

    assert_master_low_wins_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !sda_seen |-> !sda_o);
endmodule

// File: tb/test_i2c_wire_bridge.sv
module test_i2c_wire_bridge;
    localparam int CLK_PERIOD = 10;
    localparam int H = 6;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic scl_i = 1'b1;
    logic sda_i = 1'b1;
    logic sda_o;
    logic tgt_start, tgt_rnw, tgt_write, tgt_read, tgt_mnack, tgt_end, tgt_nack;
    logic [6:0] tgt_addr;
    logic [7:0] tgt_wdata, tgt_rdata;
    logic [7:0] rdc;

    int checks = 0;
    int errors = 0;
    int n_start = 0, n_write = 0, n_read = 0, n_end = 0, n_mnack = 0;
    logic [6:0] last_addr;
    logic last_rnw;
    logic [7:0] last_wdata;

    always #(CLK_PERIOD/2) clk = ~clk;

    i2c_wire_bridge i_i2c_wire_bridge (
        .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i), .sda_o(sda_o),
        .tgt_start_o(tgt_start), .tgt_addr_o(tgt_addr), .tgt_rnw_o(tgt_rnw),
        .tgt_write_o(tgt_write), .tgt_wdata_o(tgt_wdata), .tgt_nack_i(tgt_nack),
        .tgt_read_o(tgt_read), .tgt_rdata_i(tgt_rdata), .tgt_mnack_o(tgt_mnack),
        .tgt_end_o(tgt_end)
    );

    // behavioural target: only address 0x50 answers, byte 0xEE is refused
    assign tgt_nack  = tgt_start ? (tgt_addr != 7'h50) : (tgt_write && tgt_wdata == 8'hEE);
    assign tgt_rdata = 8'hC3 ^ rdc;
    always @(posedge clk) begin
        if (!rst_n) rdc <= 8'd0;
        else if (tgt_read) rdc <= rdc + 8'd1;
    end

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // ---------------- cycle reference model ----------------
    int   m_st, n_st;                  // 0 idle,1 in,2 ack,3 out,4 mack,5 muted
    int   m_cnt, n_cnt;
    logic [7:0] m_buf, n_buf;
    bit   m_av, n_av, m_rnw, n_rnw, m_drv, n_drv;
    bit   m_p1s, m_p1d, m_p2s, m_p2d, m_ls, m_ld;
    int   m_rd;
    bit   e_start, e_write, e_read, e_mnack, e_end, e_sda;
    logic [7:0] e_byte;

    always @(posedge clk) begin
        bit cond, nk;
        logic [7:0] rb;
        if (!rst_n) begin
            m_st = 0; m_cnt = 0; m_buf = 8'd0; m_av = 0; m_rnw = 0; m_drv = 1;
            n_st = 0; n_cnt = 0; n_buf = 8'd0; n_av = 0; n_rnw = 0; n_drv = 1;
            m_p1s = 1; m_p1d = 1; m_p2s = 1; m_p2d = 1; m_ls = 1; m_ld = 1; m_rd = 0;
            e_start = 0; e_write = 0; e_read = 0; e_mnack = 0; e_end = 0; e_sda = 1;
            e_byte = 8'd0;
        end else begin
            m_st = n_st; m_cnt = n_cnt; m_buf = n_buf; m_av = n_av; m_rnw = n_rnw; m_drv = n_drv;
            m_ls = m_p2s; m_ld = m_p2d; m_p2s = m_p1s; m_p2d = m_p1d; m_p1s = scl_i; m_p1d = sda_i;
            e_start = 0; e_write = 0; e_read = 0; e_mnack = 0; e_end = 0; e_byte = m_buf;
            cond = (m_p2d != m_ld) && m_ls;
            if (cond && !m_p2d) begin
                n_st = 1; n_cnt = 0; n_av = 0; n_drv = 1;
            end else if (cond) begin
                if (m_av) e_end = 1;
                n_st = 0; n_av = 0; n_drv = 1;
            end else if (m_p2s != m_ls) begin
                if (!m_p2s) n_drv = 1;
                else if (m_st == 1) begin
                    n_buf = {m_buf[6:0], m_p2d}; n_drv = 1;
                    n_cnt = m_cnt + 1; if (m_cnt == 7) n_st = 2;
                end else if (m_st == 2) begin
                    n_cnt = 0;
                    if (!m_av) begin e_start = 1; nk = (m_buf[7:1] != 7'h50); end
                    else begin e_write = 1; nk = (m_buf == 8'hEE); end
                    if (nk) begin e_end = 1; n_st = 0; n_av = 0; n_drv = 1; end
                    else begin
                        n_drv = 0;
                        if (!m_av) begin n_av = 1; n_rnw = m_buf[0]; end
                        n_st = n_rnw ? 3 : 1;
                    end
                end else if (m_st == 3) begin
                    if (m_cnt == 0) begin
                        e_read = 1; rb = 8'hC3 ^ m_rd[7:0]; m_rd++;
                        n_drv = rb[7]; n_buf = {rb[6:0], 1'b0};
                    end else begin
                        n_drv = m_buf[7]; n_buf = {m_buf[6:0], 1'b0};
                    end
                    n_cnt = m_cnt + 1; if (m_cnt == 7) n_st = 4;
                end else if (m_st == 4) begin
                    n_drv = 1; n_cnt = 0;
                    if (m_p2d) begin e_mnack = 1; n_st = 5; end else n_st = 3;
                end else n_drv = 1;
            end
            e_sda = m_drv & m_ld;
        end
    end

    // per-cycle comparison and transaction monitor
    always @(negedge clk) begin
        if (rst_n) begin
            chk(sda_o == e_sda, "R8 sda_o per cycle", sda_o, e_sda);
            chk({tgt_start, tgt_write, tgt_read, tgt_mnack, tgt_end} ==
                {e_start, e_write, e_read, e_mnack, e_end},
                "R11 request pulses per cycle",
                {tgt_start, tgt_write, tgt_read, tgt_mnack, tgt_end},
                {e_start, e_write, e_read, e_mnack, e_end});
            if (e_start) chk({tgt_addr, tgt_rnw} == e_byte, "R3 address field", {tgt_addr, tgt_rnw}, e_byte);
            if (e_write) chk(tgt_wdata == e_byte, "R3 write data", tgt_wdata, e_byte);
            if (tgt_start) begin n_start++; last_addr = tgt_addr; last_rnw = tgt_rnw; end
            if (tgt_write) begin n_write++; last_wdata = tgt_wdata; end
            if (tgt_read)  n_read++;
            if (tgt_end)   n_end++;
            if (tgt_mnack) n_mnack++;
        end
    end

    // ---------------- bit-banged master ----------------
    task automatic hold();
        repeat (H) @(posedge clk);
        #1;
    endtask

    task automatic line(input logic c, input logic d);
        scl_i = c; sda_i = d; hold();
    endtask

    task automatic bus_start();
        line(scl_i, 1'b1); line(1'b1, 1'b1); line(1'b1, 1'b0); line(1'b0, 1'b0);
    endtask

    task automatic bus_stop();
        line(1'b0, 1'b0); line(1'b1, 1'b0); line(1'b1, 1'b1);
    endtask

    task automatic write_byte(input logic [7:0] b, output logic ack);
        for (int i = 7; i >= 0; i--) begin
            line(1'b0, b[i]); line(1'b1, b[i]);
            if (!b[i]) chk(sda_o == 1'b0, "R8 master low reads low", sda_o, 0);
            line(1'b0, b[i]);
        end
        line(1'b0, 1'b1); line(1'b1, 1'b1); ack = sda_o; line(1'b0, 1'b1);
    endtask

    task automatic read_byte(input logic mnack, output logic [7:0] v);
        for (int i = 7; i >= 0; i--) begin
            line(1'b0, 1'b1); line(1'b1, 1'b1); v[i] = sda_o; line(1'b0, 1'b1);
            chk(sda_o == 1'b1, "R10 fall releases drive", sda_o, 1);
        end
        line(1'b0, mnack); line(1'b1, mnack); line(1'b0, mnack);
    endtask

    bit done = 0;
    initial begin
        logic ack;
        logic [7:0] v;
        int rd_seen;
        rd_seen = 0;
        repeat (4) @(posedge clk);
        #1 rst_n = 1'b1;
        hold();
        chk(sda_o == 1'b1, "R9 reset sda_o high", sda_o, 1);
        chk(n_start + n_write + n_read + n_end + n_mnack == 0, "R9 no requests after reset",
            n_start + n_write + n_read + n_end + n_mnack, 0);

        // write with ACK, then a refused data byte
        bus_start();
        write_byte(8'hA0, ack);
        chk(ack == 1'b0, "R4 address ACK", ack, 0);
        chk({last_addr, last_rnw} == 8'hA0, "R3 address/direction", {last_addr, last_rnw}, 8'hA0);
        write_byte(8'h3C, ack);
        chk(ack == 1'b0, "R4 data ACK", ack, 0);
        chk(last_wdata == 8'h3C, "R3 write byte MSB first", last_wdata, 8'h3C);
        write_byte(8'hEE, ack);
        chk(ack == 1'b1, "R5 refused data NACK", ack, 1);
        chk(n_end == 1, "R5 close with refusal", n_end, 1);
        write_byte(8'h55, ack);
        chk(n_write == 2, "R5 clocks ignored after refusal", n_write, 2);
        chk(ack == 1'b1, "R5 no ACK after refusal", ack, 1);
        bus_stop();
        chk(n_end == 1, "R2 STOP without open address", n_end, 1);

        // address refused
        bus_start();
        write_byte(8'h44, ack);
        chk(ack == 1'b1, "R5 address NACK", ack, 1);
        chk(n_end == 2, "R5 close on address refusal", n_end, 2);
        bus_stop();
        chk(n_end == 2, "R2 no second close", n_end, 2);

        // three-byte read ending in master NACK
        bus_start();
        write_byte(8'hA1, ack);
        chk(ack == 1'b0, "R4 read address ACK", ack, 0);
        for (int k = 0; k < 3; k++) begin
            read_byte(k == 2, v);
            chk(v == (8'hC3 ^ rd_seen[7:0]), "R6 read byte", v, 8'hC3 ^ rd_seen[7:0]);
            rd_seen++;
        end
        chk(n_mnack == 1, "R7 single master NACK", n_mnack, 1);
        read_byte(1'b1, v);
        chk(n_read == 3, "R7 no fetch after master NACK", n_read, 3);
        chk(v == 8'hFF, "R7 SDA released after master NACK", v, 8'hFF);
        bus_stop();
        chk(n_end == 3, "R2 STOP closes read", n_end, 3);

        // START by dropping both lines in one sample, then repeated START
        line(1'b0, 1'b0);
        write_byte(8'hA0, ack);
        chk(ack == 1'b0, "R10 SDA condition wins simultaneous change", ack, 0);
        write_byte(8'h11, ack);
        chk(ack == 1'b0, "R4 second write ACK", ack, 0);
        bus_start();
        chk(n_end == 3, "R1 repeated START issues no close", n_end, 3);
        write_byte(8'hA1, ack);
        chk(ack == 1'b0, "R1 address after repeated START", ack, 0);
        read_byte(1'b1, v);
        chk(v == (8'hC3 ^ rd_seen[7:0]), "R6 read after repeated START", v, 8'hC3 ^ rd_seen[7:0]);
        chk(n_start == 5, "R1 start request count", n_start, 5);
        bus_stop();
        chk(n_end == 4, "R2 final close", n_end, 4);
        hold();

        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog actual=0 expected=1");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule